// File: doc/BRIEF.md
# Change-of-Flow Program Trace Buffer

This block sits beside a CPU core and records where program flow jumped. At every retired instruction the core presents a retire strobe, a flow-event class and the instruction's source and destination addresses. When an interrupt is taken it also presents a vector address. While tracing is on and the normal mode is selected, the block writes one 19-bit entry for each qualifying event into a circular buffer. Each entry is an 18-bit address plus a flag that tells whether the address is the instruction's own location (source) or the place control went to (destination or vector). The core does the opcode decoding, so the block works only from the class code.

A trigger input ends a capture run. After a trigger the buffer is frozen until tracing is switched off and on again. Switching on from idle empties the buffer. A combinational read port returns entries by age, where index 0 is the oldest surviving entry, so software or a debug host can read the run back in order. The buffer accepts one write per clock. When an instruction entry and an interrupt vector entry arrive together, the vector is parked in a one-entry holding register and written on the following clock. This keeps the jump destination ahead of the vector.

The control is a four-state machine. IDLE: not capturing. ARMED: capturing. HOLD: writing a parked vector. DONE: stopped by a trigger. Its transitions are:
- IDLE→ARMED on enable with the normal mode, which clears the buffer.
- ARMED→HOLD on an instruction entry that comes with a vector.
- ARMED→DONE and HOLD→DONE on trigger.
- HOLD→ARMED otherwise.
- Any state other than IDLE returns to IDLE when enable drops.

Top module: `cof_trace_buffer`

## Requirements
- R1: After reset the machine is in IDLE, `entry_count` is 0 and `rd_valid` is 0.
- R2: Entries are written only while `trace_en` is 1 and capture has started with `trace_mode` = 2'b00 (normal). Raising `trace_en` from IDLE with normal mode empties the buffer. Dropping `trace_en` keeps the stored entries readable and adds no new ones.
- R3: Mode codes 2'b01, 2'b10 and 2'b11 are reserved. With any of them the block stays in IDLE and stores nothing.
- R4: A retired instruction of class 3'd1 (taken conditional branch) stores `ret_src` with flag bit 18 = 0 (source).
- R5: Class 3'd2 (indexed jump or call) and class 3'd3 (any return) store `ret_dst` with flag bit 18 = 1 (destination).
- R6: Class 3'd4 (unconditional relative branch, branch-to-subroutine, background entry, non-indexed jump or call) stores nothing. So do class 3'd0 and the unused codes 3'd5 to 3'd7.
- R7: `irq_take` with `irq_debug` = 0 stores `irq_vec` with flag = 1. With `irq_debug` = 1 it stores nothing.
- R8: When an instruction entry and a vector entry occur in the same cycle, the instruction entry is written in that cycle and the vector entry in the next. Retirements presented in that next cycle are not recorded.
- R9: After DEPTH writes, further writes overwrite the oldest entry. `entry_count` saturates at DEPTH.
- R10: While capturing, a `trigger` cycle writes none of that cycle's events and moves to DONE. Nothing more is stored until `trace_en` is dropped and raised again.
- R11: `rd_idx` = 0 addresses the oldest entry and `entry_count`-1 the newest. `rd_valid` is 1 exactly when `rd_idx` < `entry_count`. `rd_data` is {flag, address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Tracing on |
| trace_mode | input | 2 | Mode select, 2'b00 normal |
| trigger | input | 1 | Ends a capture run |
| ret_valid | input | 1 | Instruction retired this cycle |
| ret_class | input | 3 | Flow-event class of the retired instruction |
| ret_src | input | ADDR_W | Address of the retired instruction |
| ret_dst | input | ADDR_W | Address control flows to |
| irq_take | input | 1 | Interrupt taken this cycle |
| irq_debug | input | 1 | The vector belongs to debug mode |
| irq_vec | input | ADDR_W | Interrupt vector address |
| rd_idx | input | log2(DEPTH) | Read index by age |
| rd_data | output | ADDR_W+1 | {flag, address} at `rd_idx` |
| rd_valid | output | 1 | `rd_idx` holds a stored entry |
| entry_count | output | log2(DEPTH+1) | Number of stored entries |

## Verification
The bench builds the block with DEPTH = 8 and the default 18-bit addresses. The small depth makes wrap-around, saturation of the count and overwriting of the oldest entry reachable within a dozen events. The same run also covers trigger freeze, re-arming and parked vectors meeting wrap. The full address width keeps top-bit addresses such as 18'h3FFF2 in play, so a truncated field shows up in the read-back.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

    localparam logic [2:0] EV_NONE       = 3'd0;
    localparam logic [2:0] EV_BR_TAKEN   = 3'd1;
    localparam logic [2:0] EV_IDX_JUMP   = 3'd2;
    localparam logic [2:0] EV_RETURN     = 3'd3;
    localparam logic [2:0] EV_PLAIN_JUMP = 3'd4;

    localparam logic [1:0] MODE_NORMAL = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DONE  = 2'd3
    } trc_state_e;

endpackage

// File: rtl/cof_trace_classify.sv
module cof_trace_classify #(
    parameter int ADDR_W = 18,
    localparam int EW = ADDR_W + 1
) (
    input  logic              ret_valid,
    input  logic [2:0]        ret_class,
    input  logic [ADDR_W-1:0] ret_src,
    input  logic [ADDR_W-1:0] ret_dst,
    input  logic              irq_take,
    input  logic              irq_debug,
    input  logic [ADDR_W-1:0] irq_vec,
    output logic              ins_hit,
    output logic [EW-1:0]     ins_entry,
    output logic              vec_hit,
    output logic [EW-1:0]     vec_entry
);
    import cof_trace_pkg::*;

    always_comb begin
        ins_hit   = 1'b0;
        ins_entry = '0;
        if (ret_valid) begin
            unique case (ret_class)
                EV_BR_TAKEN: begin
                    ins_hit   = 1'b1;
                    ins_entry = {1'b0, ret_src};
                end
                EV_IDX_JUMP, EV_RETURN: begin
                    ins_hit   = 1'b1;
                    ins_entry = {1'b1, ret_dst};
                end
                default: begin
                    ins_hit   = 1'b0;
                    ins_entry = '0;
                end
            endcase
        end
    end

    assign vec_hit   = irq_take && !irq_debug;
    assign vec_entry = {1'b1, irq_vec};

endmodule

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl #(
    parameter int EW = 19
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trace_en,
    input  logic [1:0]                trace_mode,
    input  logic                      trigger,
    input  logic                      ins_hit,
    input  logic [EW-1:0]             ins_entry,
    input  logic                      vec_hit,
    input  logic [EW-1:0]             vec_entry,
    output logic                      wr_en,
    output logic [EW-1:0]             wr_entry,
    output logic                      clear,
    output cof_trace_pkg::trc_state_e state
);
    import cof_trace_pkg::*;

    trc_state_e state_d;
    logic [EW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hold_q <= '0;
        end else begin
            state <= state_d;
            if (state == ST_ARMED) begin
                hold_q <= vec_entry;
            end
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (trace_en && trace_mode == MODE_NORMAL) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!trace_en)                state_d = ST_IDLE;
                else if (trigger)             state_d = ST_DONE;
                else if (ins_hit && vec_hit)  state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!trace_en)     state_d = ST_IDLE;
                else if (trigger)  state_d = ST_DONE;
                else               state_d = ST_ARMED;
            end
            ST_DONE: begin
                if (!trace_en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_entry = '0;
        clear    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clear = trace_en && trace_mode == MODE_NORMAL;
            end
            ST_ARMED: begin
                if (trace_en && !trigger) begin
                    wr_en    = ins_hit || vec_hit;
                    wr_entry = ins_hit ? ins_entry : vec_entry;
                end
            end
            ST_HOLD: begin
                wr_en    = 1'b1;
                wr_entry = hold_q;
            end
            ST_DONE: begin
                wr_en = 1'b0;
            end
            default: wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
    parameter int DEPTH = 64,
    parameter int EW    = 19,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_entry,
    input  logic [PW-1:0] rd_idx,
    output logic [EW-1:0] rd_data,
    output logic          rd_valid,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic          wrap;
    logic [PW-1:0] base;
    logic [PW-1:0] phys;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            wrap <= 1'b0;
        end else if (clear) begin
            wptr <= '0;
            wrap <= 1'b0;
        end else if (wr_en) begin
            if (wptr == LAST) begin
                wptr <= '0;
                wrap <= 1'b1;
            end else begin
                wptr <= wptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            mem[wptr] <= wr_entry;
        end
    end

    always_comb begin
        base = wrap ? wptr : '0;
        phys = base + rd_idx;
        if (phys > LAST) phys = phys - PW'(DEPTH);
    end

    assign count    = wrap ? CW'(DEPTH) : CW'(wptr);
    assign rd_valid = CW'(rd_idx) < count;
    assign rd_data  = mem[phys];

endmodule

// File: rtl/cof_trace_buffer.sv
module cof_trace_buffer #(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 64,
    localparam int EW = ADDR_W + 1,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic [1:0]        trace_mode,
    input  logic              trigger,
    input  logic              ret_valid,
    input  logic [2:0]        ret_class,
    input  logic [ADDR_W-1:0] ret_src,
    input  logic [ADDR_W-1:0] ret_dst,
    input  logic              irq_take,
    input  logic              irq_debug,
    input  logic [ADDR_W-1:0] irq_vec,
    input  logic [PW-1:0]     rd_idx,
    output logic [EW-1:0]     rd_data,
    output logic              rd_valid,
    output logic [CW-1:0]     entry_count
);
    import cof_trace_pkg::*;

    logic          ins_hit, vec_hit, wr_en, clear;
    logic [EW-1:0] ins_entry, vec_entry, wr_entry;
    trc_state_e    st;

    cof_trace_classify #(.ADDR_W(ADDR_W)) u_classify (
        .ret_valid (ret_valid),
        .ret_class (ret_class),
        .ret_src   (ret_src),
        .ret_dst   (ret_dst),
        .irq_take  (irq_take),
        .irq_debug (irq_debug),
        .irq_vec   (irq_vec),
        .ins_hit   (ins_hit),
        .ins_entry (ins_entry),
        .vec_hit   (vec_hit),
        .vec_entry (vec_entry)
    );

    cof_trace_ctrl #(.EW(EW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trace_en   (trace_en),
        .trace_mode (trace_mode),
        .trigger    (trigger),
        .ins_hit    (ins_hit),
        .ins_entry  (ins_entry),
        .vec_hit    (vec_hit),
        .vec_entry  (vec_entry),
        .wr_en      (wr_en),
        .wr_entry   (wr_entry),
        .clear      (clear),
        .state      (st)
    );

    cof_trace_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .count    (entry_count)
    );

endmodule

// File: rtl/cof_trace_chk.sv
module cof_trace_chk #(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      trace_en,
    input logic [1:0]                trace_mode,
    input logic                      trigger,
    input logic                      ret_valid,
    input logic [2:0]                ret_class,
    input logic                      irq_take,
    input logic                      irq_debug,
    input logic [CW-1:0]             entry_count,
    input cof_trace_pkg::trc_state_e state
);
    import cof_trace_pkg::*;

    logic ins_cls;
    assign ins_cls = ret_valid && (ret_class == EV_BR_TAKEN || ret_class == EV_IDX_JUMP
                                   || ret_class == EV_RETURN);

    // R2
    disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trace_en && state != ST_HOLD) |=> $stable(entry_count));

    // R3
    reserved_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trace_mode != MODE_NORMAL) |=> state == ST_IDLE);

    // R6
    plain_jump_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && trace_en && !trigger && ret_valid
         && ret_class == EV_PLAIN_JUMP && !irq_take) |=> $stable(entry_count));

    // R8
    vector_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && trace_en && !trigger && ins_cls && irq_take && !irq_debug)
        |=> state == ST_HOLD);

    // R9
    count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CW'(DEPTH));

    // R10
    trigger_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && trace_en && trigger)
        |=> (state == ST_DONE && $stable(entry_count)));

endmodule

bind cof_trace_buffer cof_trace_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trace_en    (trace_en),
    .trace_mode  (trace_mode),
    .trigger     (trigger),
    .ret_valid   (ret_valid),
    .ret_class   (ret_class),
    .irq_take    (irq_take),
    .irq_debug   (irq_debug),
    .entry_count (entry_count),
    .state       (st)
);

// File: tb/tb_cof_trace_buffer.sv
module tb_cof_trace_buffer;
    localparam int AW = 18;
    localparam int DEPTH = 8;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trace_en = 1'b0;
    logic [1:0] trace_mode = 2'b00;
    logic trigger = 1'b0;
    logic ret_valid = 1'b0;
    logic [2:0] ret_class = 3'd0;
    logic [AW-1:0] ret_src = '0, ret_dst = '0, irq_vec = '0;
    logic irq_take = 1'b0, irq_debug = 1'b0;
    logic [PW-1:0] rd_idx = '0;
    logic [AW:0] rd_data;
    logic rd_valid;
    logic [CW-1:0] entry_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cof_trace_buffer #(.ADDR_W(AW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .trace_mode(trace_mode),
        .trigger(trigger), .ret_valid(ret_valid), .ret_class(ret_class),
        .ret_src(ret_src), .ret_dst(ret_dst), .irq_take(irq_take),
        .irq_debug(irq_debug), .irq_vec(irq_vec), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid), .entry_count(entry_count)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: queue of entries, oldest first
    logic [AW:0] q[$];
    bit m_on, m_stop, m_pend;
    logic [AW:0] m_pend_e;

    task automatic m_push(logic [AW:0] e);
        q.push_back(e);
        if (q.size() > DEPTH) void'(q.pop_front());
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_on = 0; m_stop = 0; m_pend = 0;
        end else if (m_pend) begin
            m_push(m_pend_e);
            m_pend = 0;
            if (!trace_en) m_on = 0;
            else if (trigger) m_stop = 1;
        end else if (!m_on) begin
            if (trace_en && trace_mode == 2'b00) begin
                m_on = 1; m_stop = 0; q.delete();
            end
        end else if (!trace_en) begin
            m_on = 0;
        end else if (!m_stop) begin
            if (trigger) m_stop = 1;
            else begin
                bit ih;
                logic [AW:0] ie;
                ih = 0; ie = '0;
                if (ret_valid && ret_class == 3'd1) begin ih = 1; ie = {1'b0, ret_src}; end
                if (ret_valid && (ret_class == 3'd2 || ret_class == 3'd3)) begin
                    ih = 1; ie = {1'b1, ret_dst};
                end
                if (ih) m_push(ie);
                if (irq_take && !irq_debug) begin
                    if (ih) begin m_pend = 1; m_pend_e = {1'b1, irq_vec}; end
                    else m_push({1'b1, irq_vec});
                end
            end
        end
    end

    // Per-cycle comparison against the reference (R11 read-back, R9 count)
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R9 count vs model", 32'(entry_count), 32'(q.size()));
            check("R11 rd_valid vs model", 32'(rd_valid), 32'(int'(rd_idx) < q.size()));
            if (int'(rd_idx) < q.size())
                check("R11 rd_data vs model", 32'(rd_data), 32'(q[rd_idx]));
        end
    end

    task automatic clr_in();
        trigger = 0; ret_valid = 0; ret_class = 3'd0; irq_take = 0; irq_debug = 0;
    endtask

    task automatic ev(logic [2:0] cls, logic [AW-1:0] s, logic [AW-1:0] d,
                      bit irq, bit dbg, logic [AW-1:0] v, bit trg);
        @(negedge clk);
        ret_valid = (cls != 3'd0); ret_class = cls; ret_src = s; ret_dst = d;
        irq_take = irq; irq_debug = dbg; irq_vec = v; trigger = trg;
        @(negedge clk);
        clr_in();
    endtask

    task automatic expect_entry(string req, int idx, logic [AW:0] exp);
        @(negedge clk);
        rd_idx = PW'(idx);
        #1;
        check(req, 32'(rd_valid), 32'd1);
        check(req, 32'(rd_data), 32'(exp));
    endtask

    task automatic expect_count(string req, int exp);
        @(negedge clk);
        #1;
        check(req, 32'(entry_count), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset count", 32'(entry_count), 32'd0);
        check("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        rst_n = 1;

        // R3 reserved mode
        @(negedge clk); trace_en = 1; trace_mode = 2'b01;
        ev(3'd1, 18'h00123, 18'h0, 0, 0, 18'h0, 0);
        ev(3'd2, 18'h0, 18'h00456, 1, 0, 18'h3FFF0, 0);
        expect_count("R3 reserved mode stores nothing", 0);
        @(negedge clk); trace_en = 0; trace_mode = 2'b00;
        @(negedge clk); trace_en = 1;
        @(negedge clk);

        ev(3'd1, 18'h10004, 18'h2AAAA, 0, 0, 18'h0, 0);
        expect_entry("R4 branch source", 0, {1'b0, 18'h10004});
        ev(3'd4, 18'h11111, 18'h22222, 0, 0, 18'h0, 0);
        ev(3'd6, 18'h11111, 18'h22222, 0, 0, 18'h0, 0);
        expect_count("R6 plain jump and unused class ignored", 1);
        ev(3'd2, 18'h00777, 18'h20100, 1, 0, 18'h3FFF2, 0);
        expect_entry("R8 destination first", 1, {1'b1, 18'h20100});
        expect_entry("R8 vector second", 2, {1'b1, 18'h3FFF2});
        ev(3'd3, 18'h00888, 18'h00500, 0, 0, 18'h0, 0);
        expect_entry("R5 return destination", 3, {1'b1, 18'h00500});
        ev(3'd0, 18'h0, 18'h0, 1, 1, 18'h3FFF6, 0);
        expect_count("R7 debug vector ignored", 4);
        ev(3'd0, 18'h0, 18'h0, 1, 0, 18'h3FFF8, 0);
        expect_entry("R7 interrupt vector", 4, {1'b1, 18'h3FFF8});

        for (int i = 0; i < 6; i++) ev(3'd1, 18'(i + 18'h100), 18'h0, 0, 0, 18'h0, 0);
        expect_count("R9 count saturates", DEPTH);
        expect_entry("R9 oldest overwritten", 0, {1'b1, 18'h00500});
        expect_entry("R11 newest last", DEPTH - 1, {1'b0, 18'h105});

        ev(3'd1, 18'h0ABCD, 18'h0, 0, 0, 18'h0, 1);
        expect_entry("R10 trigger event not stored", DEPTH - 1, {1'b0, 18'h105});
        ev(3'd3, 18'h0, 18'h01234, 0, 0, 18'h0, 0);
        expect_entry("R10 frozen after trigger", DEPTH - 1, {1'b0, 18'h105});

        @(negedge clk); trace_en = 0;
        ev(3'd1, 18'h05555, 18'h0, 0, 0, 18'h0, 0);
        expect_count("R2 disabled keeps contents", DEPTH);
        @(negedge clk); trace_en = 1;
        expect_count("R2 re-arm clears", 0);
        ev(3'd2, 18'h0, 18'h3FFFF, 0, 0, 18'h0, 0);
        expect_entry("R2 capture after re-arm", 0, {1'b1, 18'h3FFFF});

        // Random phase against the reference
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            ret_valid = ($urandom_range(0, 3) != 0);
            ret_class = 3'($urandom_range(0, 7));
            ret_src = 18'($urandom); ret_dst = 18'($urandom); irq_vec = 18'($urandom);
            irq_take = ($urandom_range(0, 4) == 0);
            irq_debug = ($urandom_range(0, 3) == 0);
            trigger = ($urandom_range(0, 60) == 0);
            if ($urandom_range(0, 80) == 0) trace_en = ~trace_en;
            trace_mode = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            rd_idx = PW'($urandom);
        end
        @(negedge clk); clr_in();
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        done = 1;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule